// File: doc/BRIEF.md
# Incrementing Audio Pattern Checker

This block watches a stream of audio sample beats and confirms that the sample values climb by exactly one from beat to beat. Each beat carries a sample, a few per-sample side bits, an even-parity bit and a frame-start marker. The channel number of the beat is carried on a separate ID lane. While the block is enabled it counts every beat it accepts. It also counts every beat whose value breaks the climbing sequence. For each kind of fault (sequence break, channel-order break, parity, missing frame marker) it raises a sticky flag.

The first sequence break freezes three diagnostic values: the channel it arrived on, the value that arrived, and the value that came before it. After that the counters keep running and the flags keep collecting, but the frozen values do not change. Dropping the enable, or pulsing the clear input, wipes all of this state. A bus-side wrapper is expected to present the status word, the two counters and the two frozen values as read-only registers.

Beat layout on `sTdata`, counting from bit 0 (SAMPLE_W = sample width):

| Bits | Content |
|---|---|
| [SAMPLE_W-1:0] | sample value |
| [SAMPLE_W+2:SAMPLE_W] | side bits (carried, covered by parity) |
| [SAMPLE_W+3] | parity bit |
| [SAMPLE_W+4] | frame-start marker |

Top module: `aud_seq_chk`

## Requirements
- R1: After reset, in any cycle with `start` low, and in any cycle with `clear` high, every counter, flag and captured value returns to zero on the next edge. Clearing wins over a beat presented in the same cycle.
- R2: A beat is accepted when `sTvalid` is high, `start` is high and `clear` is low. Each accepted beat raises `validCnt` by one. A cycle with `sTvalid` low changes nothing.
- R3: Status bit 5+CH_W (bit 8 by default) is the started flag. It sets on the first accepted beat and stays set until cleared.
- R4: The first accepted beat after a clear only seeds the reference and is never a mismatch. Every later accepted beat is a mismatch when its sample differs from the reference plus one, modulo 2^SAMPLE_W. A mismatch sets sticky status bit 1 and raises `missCnt` by one. After every accepted beat, the reference takes the received sample.
- R5: On the first mismatch after a clear, status bits [4+CH_W:5] take `sTid`, `rxCapt` takes the received sample, and `prevCapt` takes the reference. Later mismatches leave all three unchanged.
- R6: The expected channel starts at 0. An accepted beat whose `sTid` differs from it sets sticky status bit 2. The next expected channel is `sTid`+1, or 0 when `sTid` is NUM_CH-1 or more.
- R7: An accepted beat whose bits [SAMPLE_W+3:0] have odd parity (their XOR is 1) sets sticky status bit 3.
- R8: An accepted beat with `sTid` = 0 and the frame-start marker bit SAMPLE_W+4 low sets sticky status bit 4. A low marker on any other channel is not an error.
- R9: Both counters stop at their all-ones value instead of wrapping.
- R10: Status bit 0 is high whenever any of status bits 1 to 4 is high. All unlisted status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| start | input | 1 | enable; low holds the checker cleared |
| clear | input | 1 | synchronous wipe of all state |
| sTvalid | input | 1 | beat present on the stream |
| sTdata | input | SAMPLE_W+5 | beat payload, layout above |
| sTid | input | CH_W | channel number of the beat |
| status | output | 32 | flags, first-error channel, started flag |
| validCnt | output | CNT_W | accepted beat count, saturating |
| missCnt | output | CNT_W | mismatch count, saturating |
| rxCapt | output | SAMPLE_W | sample received at the first mismatch |
| prevCapt | output | SAMPLE_W | reference held at the first mismatch |

## Verification
The bench builds the block with CNT_W = 4 and NUM_CH = 4, and keeps the default 24-bit sample. A 4-bit counter reaches its ceiling within eighteen beats, so saturation of both counters is exercised, not just argued. Four channels let the channel-ID check go through a full 0-to-3 wrap and see an out-of-order start. The full sample width leaves room for the all-ones-to-zero step of the sequence, which must not count as a mismatch.

// File: rtl/aud_seq_chk_pkg.sv
package aud_seq_chk_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic clr;        // wipe all state
    logic take;       // beat accepted this cycle
    logic missHit;    // accepted beat breaks the sequence
    logic firstMiss;  // first break since the last wipe
  } strobe_t;

  // Sticky fault flags
  typedef struct packed {
    logic pre;
    logic par;
    logic id;
    logic seq;
  } errFlags_t;

endpackage

// File: rtl/aud_seq_chk_satcnt.sv
module aud_seq_chk_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/aud_seq_chk_ctrl.sv
module aud_seq_chk_ctrl
  import aud_seq_chk_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CH_W     = 3,
  parameter int NUM_CH   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                clear,
  input  logic                sTvalid,
  input  logic [SAMPLE_W+4:0] sTdata,
  input  logic [CH_W-1:0]     sTid,
  input  logic                seqMiss,
  output strobe_t             strb,
  output errFlags_t           errs,
  output logic                started,
  output logic [CH_W-1:0]     firstCh
);

  localparam int              PAR_TOP  = SAMPLE_W + 3;
  localparam int              MARK_BIT = SAMPLE_W + 4;
  localparam logic [CH_W-1:0] LAST_CH  = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] expCh;
  logic [CH_W-1:0] nextCh;
  logic            parityBad;
  logic            preambleBad;
  logic            idBad;

  always_comb begin
    parityBad      = ^sTdata[PAR_TOP:0];
    preambleBad    = (sTid == '0) && !sTdata[MARK_BIT];
    idBad          = (sTid != expCh);
    nextCh         = (sTid >= LAST_CH) ? '0 : sTid + CH_W'(1);
    strb.clr       = !start || clear;
    strb.take      = !strb.clr && sTvalid;
    strb.missHit   = strb.take && seqMiss;
    strb.firstMiss = strb.missHit && !errs.seq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errs    <= '0;
      started <= 1'b0;
      expCh   <= '0;
      firstCh <= '0;
    end else if (strb.clr) begin
      errs    <= '0;
      started <= 1'b0;
      expCh   <= '0;
      firstCh <= '0;
    end else if (strb.take) begin
      started  <= 1'b1;
      expCh    <= nextCh;
      errs.id  <= errs.id  | idBad;
      errs.par <= errs.par | parityBad;
      errs.pre <= errs.pre | preambleBad;
      errs.seq <= errs.seq | seqMiss;
      if (strb.firstMiss) firstCh <= sTid;
    end
  end

endmodule

// File: rtl/aud_seq_chk_dp.sv
module aud_seq_chk_dp
  import aud_seq_chk_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                seqMiss,
  output logic [CNT_W-1:0]    validCnt,
  output logic [CNT_W-1:0]    missCnt,
  output logic [SAMPLE_W-1:0] rxCapt,
  output logic [SAMPLE_W-1:0] prevCapt
);

  localparam int NUM_CNT = 2;

  logic [SAMPLE_W-1:0] refVal;
  logic                seeded;
  logic [NUM_CNT-1:0]  incVec;
  logic [CNT_W-1:0]    cntArr [NUM_CNT];

  assign seqMiss = seeded && (sample != refVal + SAMPLE_W'(1));
  assign incVec  = {strb.missHit, strb.take};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    aud_seq_chk_satcnt #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strb.clr),
      .inc  (incVec[g]),
      .cnt  (cntArr[g])
    );
  end

  assign validCnt = cntArr[0];
  assign missCnt  = cntArr[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refVal   <= '0;
      seeded   <= 1'b0;
      rxCapt   <= '0;
      prevCapt <= '0;
    end else if (strb.clr) begin
      refVal   <= '0;
      seeded   <= 1'b0;
      rxCapt   <= '0;
      prevCapt <= '0;
    end else if (strb.take) begin
      refVal <= sample;
      seeded <= 1'b1;
      if (strb.firstMiss) begin
        rxCapt   <= sample;
        prevCapt <= refVal;
      end
    end
  end

endmodule

// File: rtl/aud_seq_chk.sv
module aud_seq_chk
  import aud_seq_chk_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 32,
  parameter int CH_W     = 3,
  parameter int NUM_CH   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                clear,
  input  logic                sTvalid,
  input  logic [SAMPLE_W+4:0] sTdata,
  input  logic [CH_W-1:0]     sTid,
  output logic [31:0]         status,
  output logic [CNT_W-1:0]    validCnt,
  output logic [CNT_W-1:0]    missCnt,
  output logic [SAMPLE_W-1:0] rxCapt,
  output logic [SAMPLE_W-1:0] prevCapt
);

  localparam int CH_LO       = 5;
  localparam int CH_HI       = CH_LO + CH_W - 1;
  localparam int STARTED_BIT = CH_HI + 1;

  strobe_t         strb;
  errFlags_t       errs;
  logic            started;
  logic            seqMiss;
  logic [CH_W-1:0] firstCh;

  aud_seq_chk_ctrl #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W), .NUM_CH(NUM_CH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .clear   (clear),
    .sTvalid (sTvalid),
    .sTdata  (sTdata),
    .sTid    (sTid),
    .seqMiss (seqMiss),
    .strb    (strb),
    .errs    (errs),
    .started (started),
    .firstCh (firstCh)
  );

  aud_seq_chk_dp #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sample   (sTdata[SAMPLE_W-1:0]),
    .seqMiss  (seqMiss),
    .validCnt (validCnt),
    .missCnt  (missCnt),
    .rxCapt   (rxCapt),
    .prevCapt (prevCapt)
  );

  always_comb begin
    status              = '0;
    status[0]           = |errs;
    status[1]           = errs.seq;
    status[2]           = errs.id;
    status[3]           = errs.par;
    status[4]           = errs.pre;
    status[CH_HI:CH_LO] = firstCh;
    status[STARTED_BIT] = started;
  end

endmodule

// File: rtl/aud_seq_chk_sva.sv
module aud_seq_chk_sva #(
  parameter int SAMPLE_W    = 24,
  parameter int CNT_W       = 32,
  parameter int STARTED_BIT = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                clear,
  input logic                sTvalid,
  input logic [31:0]         status,
  input logic [CNT_W-1:0]    validCnt,
  input logic [CNT_W-1:0]    missCnt,
  input logic [SAMPLE_W-1:0] rxCapt,
  input logic [SAMPLE_W-1:0] prevCapt
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  a_r1_clear_wipes: assert property (@(posedge clk) disable iff (!rstN)
    (!start || clear) |=> (validCnt == '0 && missCnt == '0 && status == '0
                           && rxCapt == '0 && prevCapt == '0));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (start && !clear && sTvalid && validCnt != CNT_TOP)
      |=> validCnt == $past(validCnt) + CNT_W'(1));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (start && !clear && !sTvalid) |=> $stable(validCnt) && $stable(missCnt));

  a_r3_started_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[STARTED_BIT]) |-> $past(clear || !start));

  a_r4_miss_bounded: assert property (@(posedge clk) disable iff (!rstN)
    missCnt <= validCnt);

  a_r5_capture_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (start && !clear && status[1]) |=> $stable(rxCapt) && $stable(prevCapt));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (validCnt == CNT_TOP && start && !clear) |=> validCnt == CNT_TOP);

endmodule

bind aud_seq_chk aud_seq_chk_sva #(
  .SAMPLE_W    (SAMPLE_W),
  .CNT_W       (CNT_W),
  .STARTED_BIT (5 + CH_W)
) u_sva (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .clear    (clear),
  .sTvalid  (sTvalid),
  .status   (status),
  .validCnt (validCnt),
  .missCnt  (missCnt),
  .rxCapt   (rxCapt),
  .prevCapt (prevCapt)
);

// File: tb/aud_seq_chk_tb_top.sv
module aud_seq_chk_tb_top;

  localparam int SW  = 24;
  localparam int CW  = 4;
  localparam int HW  = 3;
  localparam int NCH = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          clear = 1'b0;
  logic          sTvalid = 1'b0;
  logic [SW+4:0] sTdata = '0;
  logic [HW-1:0] sTid = '0;
  logic [31:0]   status;
  logic [CW-1:0] validCnt, missCnt;
  logic [SW-1:0] rxCapt, prevCapt;

  always #5 clk = ~clk;

  aud_seq_chk #(.SAMPLE_W(SW), .CNT_W(CW), .CH_W(HW), .NUM_CH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .clear(clear), .sTvalid(sTvalid),
    .sTdata(sTdata), .sTid(sTid), .status(status), .validCnt(validCnt),
    .missCnt(missCnt), .rxCapt(rxCapt), .prevCapt(prevCapt)
  );

  typedef struct {
    logic [CW-1:0] v;
    logic [CW-1:0] m;
    logic [31:0]   st;
    logic [SW-1:0] rx;
    logic [SW-1:0] pv;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  // reference model state
  logic [CW-1:0] mValid, mMiss;
  logic [SW-1:0] mRef, mRx, mPrev;
  logic [HW-1:0] mExpCh, mCh;
  bit mSeeded, mStarted, mSeq, mId, mPar, mPre;

  task automatic modelWipe();
    mValid = '0; mMiss = '0; mRef = '0; mRx = '0; mPrev = '0;
    mExpCh = '0; mCh = '0;
    mSeeded = 0; mStarted = 0; mSeq = 0; mId = 0; mPar = 0; mPre = 0;
  endtask

  task automatic chkField(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus plus the expected state after the edge
  task automatic step(bit st, bit cl, bit vl, logic [SW-1:0] smp, logic [HW-1:0] tid,
                      bit mark, bit parBad, string tag);
    logic [SW+2:0] low;
    exp_t e;
    @(negedge clk);
    low     = {3'b000, smp};
    start   = st;
    clear   = cl;
    sTvalid = vl;
    sTid    = tid;
    sTdata  = {mark, (^low) ^ parBad, low};
    if (!st || cl) modelWipe();
    else if (vl) begin
      if (parBad) mPar = 1;
      if (tid == 0 && !mark) mPre = 1;
      if (tid != mExpCh) mId = 1;
      mExpCh = (int'(tid) >= NCH - 1) ? '0 : tid + HW'(1);
      if (mSeeded && smp != mRef + SW'(1)) begin
        if (mMiss != '1) mMiss = mMiss + CW'(1);
        if (!mSeq) begin
          mCh = tid; mRx = smp; mPrev = mRef;
        end
        mSeq = 1;
      end
      mRef = smp;
      mSeeded = 1;
      mStarted = 1;
      if (mValid != '1) mValid = mValid + CW'(1);
    end
    e.v   = mValid;
    e.m   = mMiss;
    e.st  = {23'b0, mStarted, mCh, mPre, mPar, mId, mSeq, (mPre | mPar | mId | mSeq)};
    e.rx  = mRx;
    e.pv  = mPrev;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops one expectation per edge and compares after the edge
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      #1;
      e = q.pop_front();
      chkField(e.tag, "validCnt", 32'(validCnt), 32'(e.v));
      chkField(e.tag, "missCnt",  32'(missCnt),  32'(e.m));
      chkField(e.tag, "status",   status,        e.st);
      chkField(e.tag, "rxCapt",   32'(rxCapt),   32'(e.rx));
      chkField(e.tag, "prevCapt", 32'(prevCapt), 32'(e.pv));
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    modelWipe();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chkField("R1 reset", "validCnt", 32'(validCnt), 0);
    chkField("R1 reset", "missCnt",  32'(missCnt),  0);
    chkField("R1 reset", "status",   status,        0);
    chkField("R1 reset", "rxCapt",   32'(rxCapt),   0);

    step(0, 0, 0, 0, 0, 0, 0, "R1 idle");

    // clean run, first mismatch on channel 2
    step(1, 0, 1, 24'd10, 0, 1, 0, "R3 first beat seeds");
    step(1, 0, 1, 24'd11, 1, 0, 0, "R4 in sequence");
    step(1, 0, 0, 24'd99, 3, 0, 0, "R2 no valid no change");
    step(1, 0, 1, 24'd30, 2, 0, 0, "R5 first mismatch capture");
    step(1, 0, 1, 24'd31, 3, 0, 0, "R4 resync to received");
    step(1, 0, 1, 24'd40, 0, 1, 0, "R5 later mismatch frozen");
    step(0, 0, 1, 24'd41, 1, 0, 0, "R1 start low wipes");
    step(0, 0, 1, 24'd42, 2, 0, 0, "R2 ignored while stopped");

    // parity fault, then clear colliding with a beat
    step(1, 0, 1, 24'd100, 0, 1, 1, "R7 odd parity");
    step(1, 0, 1, 24'd101, 1, 0, 0, "R10 summary bit");
    step(1, 1, 1, 24'd102, 2, 0, 0, "R1 clear beats a beat");

    // channel order
    step(1, 0, 1, 24'd5, 1, 0, 0, "R6 wrong first channel");
    step(1, 0, 1, 24'd6, 2, 0, 0, "R6 follows received");
    step(1, 1, 0, 24'd0, 0, 0, 0, "R1 clear");
    step(1, 0, 1, 24'd1, 0, 1, 0, "R6 order 0");
    step(1, 0, 1, 24'd2, 1, 0, 0, "R6 order 1");
    step(1, 0, 1, 24'd3, 2, 0, 0, "R6 order 2");
    step(1, 0, 1, 24'd4, 3, 0, 0, "R6 order 3");
    step(1, 0, 1, 24'd5, 0, 1, 0, "R6 wrap to 0");
    step(1, 1, 0, 24'd0, 0, 0, 0, "R1 clear");

    // frame marker
    step(1, 0, 1, 24'd7, 0, 0, 0, "R8 channel 0 without marker");
    step(1, 1, 0, 24'd0, 0, 0, 0, "R1 clear");
    step(1, 0, 1, 24'd7, 0, 1, 0, "R8 marker present");
    step(1, 0, 1, 24'd8, 1, 0, 0, "R8 no marker on channel 1 is fine");
    step(1, 1, 0, 24'd0, 0, 0, 0, "R1 clear");

    // sample wrap
    step(1, 0, 1, 24'hFFFFFF, 0, 1, 0, "R4 all ones");
    step(1, 0, 1, 24'h000000, 1, 0, 0, "R4 wrap to zero not a miss");
    step(1, 1, 0, 24'd0, 0, 0, 0, "R1 clear");

    // saturation: every beat after the first breaks the sequence
    for (int i = 0; i < 18; i++)
      step(1, 0, 1, SW'(i * 2), HW'(i % NCH), (i % NCH) == 0, 0, "R9 saturate");
    step(0, 0, 0, 24'd0, 0, 0, 0, "R1 stop");

    repeat (3) @(posedge clk);
    finish();
  end

endmodule